// File: doc/BRIEF.md
# Machine State Register Write Controller

This block holds a processor's machine state register and filters every write to it. A write request carries a proposed value and a qualifier that says whether the write may change the hypervisor bit. The block clears the bits that the implementation does not allow software to write. It keeps the hypervisor bit unless the rules allow a change. On a server-class configuration it also forces some bits on when problem state is entered. It then loads the result.

From the loaded value the block derives two three-bit memory-context indices, one for instruction fetch and one for data access, and a hidden-flags word. It also raises one-cycle strobes for neighbouring logic: a translation-context exit, a swap of four general registers with their shadow copies, an exception-prefix update, and a halt request. A configuration input selects between the embedded and the server index encodings. The register file, the TLB and the interrupt controller sit outside the block and only receive these strobes.

Top module: `msr_write_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the register loads `RESET_VAL` (default 0x1000_0040), all four strobes are 0, `excp_base` follows bit EP of the reset value, and the indices and hidden flags are derived from the reset value.
- R2: A write stores `wr_data & WR_MASK` (default mask 0x1FFF_FF7F, so bits 31:29 and 7 always read 0), except where R3 and R6 override a bit.
- R3: The hypervisor bit (bit 28) takes the written value only when `wr_alter_hv` is 1 and the current hypervisor bit is 1; otherwise it keeps its current value.
- R4: With `cfg_embedded`=0 each index is (PR?0:1) + (relocate bit clear?2:0) + (HV?4:0), where PR is bit 14, IR (bit 5) is used for fetch, DR (bit 4) for data, and HV is bit 28.
- R5: With `cfg_embedded`=1 each index is (PR?0:1) + (space bit set?2:0) + (GS?4:0), where IS (bit 5) is used for fetch, DS (bit 4) for data, and GS is bit 27.
- R6: With `cfg_embedded`=0, a written value whose PR bit (14) is 1 also stores EE (bit 15), IR and DR as 1. With `cfg_embedded`=1 no bit is forced.
- R7: `ctx_exit` pulses for one cycle after a write that changes IR or DR, or that changes GS while `cfg_embedded`=1.
- R8: `gpr_swap` pulses for one cycle after a write that changes bit TGPR (17) while `cfg_tgpr_en`=1.
- R9: `prefix_upd` pulses for one cycle after a write that changes bit EP (6), and `excp_base` then becomes 0xFFF0_0000 if EP is 1 and 0 if EP is 0.
- R10: `halt_req` pulses for one cycle after a write whose stored POW bit (18) is 1 while `irq_pending`=0 and `pow_ok`=1 at the write.
- R11: `hflags` becomes (stored value & `HFLAG_MASK`) | `ext_hflags` sampled at the write (default mask 0x1000_4031).
- R12: With `wr_en` low, the register, indices, hidden flags and exception base hold, and all strobes read 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request strobe |
| wr_data | input | XLEN | Proposed register value |
| wr_alter_hv | input | 1 | Write may change the hypervisor bit |
| cfg_embedded | input | 1 | 1 selects the embedded encoding, 0 the server rules |
| cfg_tgpr_en | input | 1 | Temporary-register swap feature present |
| irq_pending | input | 1 | An interrupt is pending |
| pow_ok | input | 1 | External power-save check passes |
| ext_hflags | input | XLEN | Flags from other registers merged into hflags |
| msr_q | output | XLEN | Current register value |
| immu_idx | output | 3 | Instruction-side memory-context index |
| dmmu_idx | output | 3 | Data-side memory-context index |
| hflags | output | XLEN | Hidden-flags word |
| excp_base | output | 32 | Exception vector base |
| ctx_exit | output | 1 | Translation-context exit strobe |
| gpr_swap | output | 1 | Register/shadow swap strobe |
| prefix_upd | output | 1 | Exception-prefix update strobe |
| halt_req | output | 1 | Halt request strobe |

## Verification
A corrupted register value shows at `msr_q` one cycle after the write that caused it. It then stays wrong at the index and hidden-flag outputs until the next write, and it turns the strobe comparisons of that next write wrong. Because the strobes depend on the difference between the old and new values, one wrong stored bit shows up twice: once as a wrong level and once as a missing or extra pulse on the following write. The random writes flip single bits often, so this second effect appears within a few writes.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam logic [31:0] EXCP_BASE_HIGH = 32'hFFF0_0000;

    typedef enum logic {
        ENC_SERVER   = 1'b0,
        ENC_EMBEDDED = 1'b1
    } msr_enc_e;

    // Bits of the register that drive side effects.
    typedef struct packed {
        logic pow;
        logic tgpr;
        logic gs;
        logic ep;
        logic ir;
        logic dr;
    } msr_view_t;

    // One-cycle side-effect strobes.
    typedef struct packed {
        logic ctx_exit;
        logic gpr_swap;
        logic prefix_upd;
        logic halt;
    } msr_fx_t;

    // Memory-context index: user/kernel, translation or space, hv or guest.
    function automatic logic [2:0] ctx_index(
        input msr_enc_e enc,
        input logic     pr,
        input logic     xlate,
        input logic     space,
        input logic     hv,
        input logic     gs
    );
        logic [2:0] idx;
        idx = pr ? 3'd0 : 3'd1;
        if (enc == ENC_EMBEDDED) begin
            idx = idx + (space ? 3'd2 : 3'd0);
            idx = idx + (gs ? 3'd4 : 3'd0);
        end else begin
            idx = idx + (xlate ? 3'd0 : 3'd2);
            idx = idx + (hv ? 3'd4 : 3'd0);
        end
        return idx;
    endfunction

endpackage

// File: rtl/msr_wr_filter.sv
module msr_wr_filter
    import msr_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter logic [XLEN-1:0] WR_MASK = '1,
    parameter int              HV_BIT  = 28,
    parameter int              PR_BIT  = 14,
    parameter int              EE_BIT  = 15,
    parameter int              IR_BIT  = 5,
    parameter int              DR_BIT  = 4
) (
    input  logic [XLEN-1:0] data,
    input  logic            cur_hv,
    input  logic            alter_hv,
    input  msr_enc_e        enc,
    output logic [XLEN-1:0] value
);
    always_comb begin
        value = data & WR_MASK;
        if (!(alter_hv && cur_hv)) begin
            value[HV_BIT] = cur_hv;
        end
        if (enc == ENC_SERVER && value[PR_BIT]) begin
            value[EE_BIT] = 1'b1;
            value[IR_BIT] = 1'b1;
            value[DR_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/msr_idx_enc.sv
module msr_idx_enc
    import msr_pkg::*;
(
    input  msr_enc_e   enc,
    input  logic       pr,
    input  logic       xlate,
    input  logic       space,
    input  logic       hv,
    input  logic       gs,
    output logic [2:0] idx
);
    always_comb idx = ctx_index(enc, pr, xlate, space, hv, gs);
endmodule

// File: rtl/msr_fx_detect.sv
module msr_fx_detect
    import msr_pkg::*;
(
    input  msr_view_t old_v,
    input  msr_view_t new_v,
    input  msr_enc_e  enc,
    input  logic      tgpr_en,
    input  logic      irq_pending,
    input  logic      pow_ok,
    output msr_fx_t   fx
);
    msr_view_t diff;

    always_comb begin
        diff          = old_v ^ new_v;
        fx.ctx_exit   = diff.ir || diff.dr || (enc == ENC_EMBEDDED && diff.gs);
        fx.gpr_swap   = tgpr_en && diff.tgpr;
        fx.prefix_upd = diff.ep;
        fx.halt       = new_v.pow && !irq_pending && pow_ok;
    end
endmodule

// File: rtl/msr_write_ctrl.sv
module msr_write_ctrl
    import msr_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] WR_MASK    = 32'h1FFF_FF7F,
    parameter logic [XLEN-1:0] RESET_VAL  = 32'h1000_0040,
    parameter logic [XLEN-1:0] HFLAG_MASK = 32'h1000_4031,
    parameter int              HV_BIT     = 28,
    parameter int              GS_BIT     = 27,
    parameter int              POW_BIT    = 18,
    parameter int              TGPR_BIT   = 17,
    parameter int              EE_BIT     = 15,
    parameter int              PR_BIT     = 14,
    parameter int              EP_BIT     = 6,
    parameter int              IR_BIT     = 5,
    parameter int              DR_BIT     = 4,
    parameter int              IS_BIT     = 5,
    parameter int              DS_BIT     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            wr_alter_hv,
    input  logic            cfg_embedded,
    input  logic            cfg_tgpr_en,
    input  logic            irq_pending,
    input  logic            pow_ok,
    input  logic [XLEN-1:0] ext_hflags,
    output logic [XLEN-1:0] msr_q,
    output logic [2:0]      immu_idx,
    output logic [2:0]      dmmu_idx,
    output logic [XLEN-1:0] hflags,
    output logic [31:0]     excp_base,
    output logic            ctx_exit,
    output logic            gpr_swap,
    output logic            prefix_upd,
    output logic            halt_req
);
    localparam int NSIDE = 2;  // 0 = fetch, 1 = data

    msr_enc_e        enc;
    logic [XLEN-1:0] filt_val;
    logic [XLEN-1:0] cand;
    msr_view_t       old_v, new_v;
    msr_fx_t         fx_nx, fx_q;
    logic [2:0]      idx_nx [NSIDE];

    assign enc = msr_enc_e'(cfg_embedded);

    msr_wr_filter #(
        .XLEN(XLEN), .WR_MASK(WR_MASK), .HV_BIT(HV_BIT),
        .PR_BIT(PR_BIT), .EE_BIT(EE_BIT), .IR_BIT(IR_BIT), .DR_BIT(DR_BIT)
    ) u_filter (
        .data    (wr_data),
        .cur_hv  (msr_q[HV_BIT]),
        .alter_hv(wr_alter_hv),
        .enc     (enc),
        .value   (filt_val)
    );

    // Value to load: reset value or filtered write.
    assign cand = rst ? RESET_VAL : filt_val;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam int XL_B = (s == 0) ? IR_BIT : DR_BIT;
        localparam int SP_B = (s == 0) ? IS_BIT : DS_BIT;
        msr_idx_enc u_enc (
            .enc  (enc),
            .pr   (cand[PR_BIT]),
            .xlate(cand[XL_B]),
            .space(cand[SP_B]),
            .hv   (cand[HV_BIT]),
            .gs   (cand[GS_BIT]),
            .idx  (idx_nx[s])
        );
    end

    always_comb begin
        old_v = '{pow: msr_q[POW_BIT], tgpr: msr_q[TGPR_BIT], gs: msr_q[GS_BIT],
                  ep: msr_q[EP_BIT], ir: msr_q[IR_BIT], dr: msr_q[DR_BIT]};
        new_v = '{pow: cand[POW_BIT], tgpr: cand[TGPR_BIT], gs: cand[GS_BIT],
                  ep: cand[EP_BIT], ir: cand[IR_BIT], dr: cand[DR_BIT]};
    end

    msr_fx_detect u_fx (
        .old_v      (old_v),
        .new_v      (new_v),
        .enc        (enc),
        .tgpr_en    (cfg_tgpr_en),
        .irq_pending(irq_pending),
        .pow_ok     (pow_ok),
        .fx         (fx_nx)
    );

    always_ff @(posedge clk) begin
        if (rst || wr_en) begin
            msr_q     <= cand;
            immu_idx  <= idx_nx[0];
            dmmu_idx  <= idx_nx[1];
            hflags    <= (cand & HFLAG_MASK) | ext_hflags;
            excp_base <= cand[EP_BIT] ? EXCP_BASE_HIGH : 32'h0;
        end
        if (rst || !wr_en) begin
            fx_q <= '0;
        end else begin
            fx_q <= fx_nx;
        end
    end

    assign ctx_exit   = fx_q.ctx_exit;
    assign gpr_swap   = fx_q.gpr_swap;
    assign prefix_upd = fx_q.prefix_upd;
    assign halt_req   = fx_q.halt;

    // R7, R8, R9, R10: strobes only follow a write
    assert_strobe_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        (|fx_q) |-> $past(wr_en));

    assert_hv_protected_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(wr_alter_hv && msr_q[HV_BIT])) |=> (msr_q[HV_BIT] == $past(msr_q[HV_BIT])));

    assert_pr_forces_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cfg_embedded) |=>
        (!msr_q[PR_BIT] || (msr_q[EE_BIT] && msr_q[IR_BIT] && msr_q[DR_BIT])));

    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(msr_q) && !ctx_exit && !gpr_swap && !prefix_upd && !halt_req));

    assert_prefix_edge_R9: assert property (@(posedge clk) disable iff (rst)
        prefix_upd |-> (msr_q[EP_BIT] != $past(msr_q[EP_BIT])));

    assert_halt_cond_R10: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> (msr_q[POW_BIT] && !$past(irq_pending) && $past(pow_ok)));

endmodule

// File: tb/msr_write_ctrl_test.sv
`timescale 1ns/1ps
module msr_write_ctrl_test;
    localparam logic [31:0] WMASK = 32'h1FFF_FF7F;
    localparam logic [31:0] RVAL  = 32'h1000_0040;
    localparam logic [31:0] HMASK = 32'h1000_4031;
    localparam int HV = 28, GS = 27, POW = 18, TG = 17, EE = 15, PR = 14;
    localparam int EP = 6, IR = 5, DR = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_alter_hv = 1'b0;
    logic        cfg_embedded = 1'b0;
    logic        cfg_tgpr_en = 1'b0;
    logic        irq_pending = 1'b0;
    logic        pow_ok = 1'b0;
    logic [31:0] ext_hflags = '0;
    logic [31:0] msr_q, hflags, excp_base;
    logic [2:0]  immu_idx, dmmu_idx;
    logic        ctx_exit, gpr_swap, prefix_upd, halt_req;

    int tests = 0;
    int fails = 0;
    logic [31:0] cur;
    logic [2:0]  cur_i, cur_d;
    logic [31:0] cur_h, cur_b;

    always #2 clk = ~clk;

    msr_write_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_alter_hv(wr_alter_hv), .cfg_embedded(cfg_embedded),
        .cfg_tgpr_en(cfg_tgpr_en), .irq_pending(irq_pending), .pow_ok(pow_ok),
        .ext_hflags(ext_hflags), .msr_q(msr_q), .immu_idx(immu_idx),
        .dmmu_idx(dmmu_idx), .hflags(hflags), .excp_base(excp_base),
        .ctx_exit(ctx_exit), .gpr_swap(gpr_swap), .prefix_upd(prefix_upd),
        .halt_req(halt_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_next(input logic [31:0] c, input logic [31:0] d,
                                           input logic alt, input logic emb);
        logic [31:0] v;
        v = d & WMASK;
        if (!(alt && c[HV])) v[HV] = c[HV];
        if (!emb && v[PR]) begin
            v[EE] = 1'b1; v[IR] = 1'b1; v[DR] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [2:0] m_idx(input logic [31:0] v, input logic emb, input int b);
        int r;
        r = v[PR] ? 0 : 1;
        if (emb) r = r + (v[b] ? 2 : 0) + (v[GS] ? 4 : 0);
        else     r = r + (v[b] ? 0 : 2) + (v[HV] ? 4 : 0);
        return 3'(r);
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " R2 msr"}, msr_q, cur);
        chk({tag, cfg_embedded ? " R5 immu" : " R4 immu"}, 32'(immu_idx), 32'(cur_i));
        chk({tag, cfg_embedded ? " R5 dmmu" : " R4 dmmu"}, 32'(dmmu_idx), 32'(cur_d));
        chk({tag, " R11 hflags"}, hflags, cur_h);
        chk({tag, " R9 excp_base"}, excp_base, cur_b);
    endtask

    // Write at a negedge, check outputs at the following negedge.
    task automatic do_write(input logic [31:0] d, input logic alt);
        logic [31:0] n;
        logic ex_ctx, ex_sw, ex_pf, ex_h;
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_alter_hv = alt;
        n      = m_next(cur, d, alt, cfg_embedded);
        ex_ctx = (n[IR] ^ cur[IR]) | (n[DR] ^ cur[DR]) | (cfg_embedded & (n[GS] ^ cur[GS]));
        ex_sw  = cfg_tgpr_en & (n[TG] ^ cur[TG]);
        ex_pf  = n[EP] ^ cur[EP];
        ex_h   = n[POW] & ~irq_pending & pow_ok;
        cur    = n;
        cur_i  = m_idx(n, cfg_embedded, IR);
        cur_d  = m_idx(n, cfg_embedded, DR);
        cur_h  = (n & HMASK) | ext_hflags;
        cur_b  = n[EP] ? 32'hFFF0_0000 : 32'h0;
        @(negedge clk);
        wr_en = 1'b0;
        check_state("write");
        chk("R7 ctx_exit", 32'(ctx_exit), 32'(ex_ctx));
        chk("R8 gpr_swap", 32'(gpr_swap), 32'(ex_sw));
        chk("R9 prefix_upd", 32'(prefix_upd), 32'(ex_pf));
        chk("R10 halt_req", 32'(halt_req), 32'(ex_h));
    endtask

    task automatic idle_check();
        @(negedge clk);
        wr_data = $urandom; wr_alter_hv = 1'b1; ext_hflags = $urandom;
        @(negedge clk);
        check_state("R12 idle");
        chk("R12 strobes low", 32'({ctx_exit, gpr_swap, prefix_upd, halt_req}), 32'h0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        cur = RVAL; cur_i = m_idx(RVAL, 1'b0, IR); cur_d = m_idx(RVAL, 1'b0, DR);
        cur_h = RVAL & HMASK; cur_b = 32'hFFF0_0000;
        check_state("R1 reset");
        chk("R1 strobes", 32'({ctx_exit, gpr_swap, prefix_upd, halt_req}), 32'h0);

        // R3: HV clear allowed only with qualifier while HV set
        do_write(32'h0000_0000, 1'b0);
        chk("R3 hv kept without qualifier", 32'(msr_q[HV]), 32'h1);
        do_write(32'h0000_0000, 1'b1);
        chk("R3 hv cleared with qualifier", 32'(msr_q[HV]), 32'h0);
        do_write(32'h1000_0000, 1'b1);
        chk("R3 hv cannot be set when clear", 32'(msr_q[HV]), 32'h0);

        // R2: unwritable bits read zero
        do_write(32'hE000_0080, 1'b1);
        chk("R2 masked bits", msr_q & ~WMASK, 32'h0);

        // R6: PR forcing in server, none in embedded
        do_write(32'h0000_4000, 1'b0);
        chk("R6 server force", msr_q & 32'h0000_8030, 32'h0000_8030);
        cfg_embedded = 1'b1;
        do_write(32'h0000_4000, 1'b0);
        chk("R6 embedded no force", msr_q & 32'h0000_8030, 32'h0);
        // R7: GS change in embedded
        do_write(32'h0800_4000, 1'b0);
        cfg_embedded = 1'b0;
        do_write(32'h0000_4030, 1'b0);

        // R10: halt gating
        pow_ok = 1'b1; irq_pending = 1'b1;
        do_write(32'h0004_0000, 1'b0);
        irq_pending = 1'b0;
        do_write(32'h0004_0000, 1'b0);
        pow_ok = 1'b0;
        do_write(32'h0000_0000, 1'b0);
        idle_check();

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] d;
            cfg_embedded = 1'($urandom);
            cfg_tgpr_en  = 1'($urandom);
            irq_pending  = 1'($urandom);
            pow_ok       = 1'($urandom);
            ext_hflags   = ($urandom % 4 == 0) ? $urandom : 32'h0;
            if ($urandom % 2 == 0) d = cur ^ (32'h1 << ($urandom % 32));
            else                   d = $urandom;
            do_write(d, 1'($urandom));
            if (i % 37 == 0) idle_check();
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule